// File: doc/BRIEF.md
# Nested Zero-Overhead Loop Controller

This block is the hardware loop sequencer that sits beside the next-address logic of a microcoded or programmable processor. When a loop instruction executes, it records three values for the new loop: the first body address (the address just after the loop instruction), the last body address, and the number of times the body is to run. The last-address and count values come from fields of the loop instruction.

On every later instruction the block compares the program counter with the last body address of the innermost active loop. If iterations remain, it asks the next-address logic to fetch from the loop's first body address and uses up one iteration. Once the final iteration has run, it lets fetch fall through to the next sequential instruction and makes the enclosing loop the active one. Up to four loops can be nested. The three values are held in three LIFO stacks that move in lock-step under one shared pointer.

When several nested loops end on the same address, the loops are settled from the inside out in a single cycle. Every exhausted inner loop is popped, and the first enclosing loop on that address that still has iterations left takes the branch.

Top module: `loop_seq`

## Requirements
- R1: After reset no loop is active: `end_hit`, `redirect` and `loop_exit` are 0 for any `pc`, and `ovf_err` is 0.
- R2: A loop instruction (`step`=1, `loop_cmd`=1) at address A with count N ≥ 1 and last body address E makes the body A+1..E execute exactly N times. During that time `redirect` is 1 on the first N−1 visits to E and 0 on the last visit, and `loop_exit` is 1 on the last visit only.
- R3: While `redirect` is 1, `redirect_addr` equals the first body address (loop instruction address + 1) of the loop being repeated.
- R4: A loaded count of 0 or of 1 runs the body once, with no `redirect`.
- R5: `end_hit` is 1 exactly when `step`=1, `loop_cmd`=0, a loop is active and `pc` equals the last body address of the innermost active loop. `redirect` is never 1 without `end_hit`.
- R6: After an inner loop finishes, the enclosing loop is active again and keeps repeating its own body, inner loop included, for its full count.
- R7: When nested loops share a last body address, at that address every exhausted inner loop is popped in the same cycle, and the first enclosing loop on that address with iterations left is repeated.
- R8: A loop instruction issued while four loops are active is not pushed, does not disturb the active loops, and sets `ovf_err`. `ovf_err` stays 1 until reset.
- R9: Once every loop has finished, reaching a former last body address gives no `end_hit`, `redirect` or `loop_exit`. A pop with an empty stack is ignored.
- R10: In a cycle with `step`=0, `redirect` and `end_hit` are 0 and no iteration is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | The instruction at `pc` executes this cycle |
| loop_cmd | input | 1 | The executing instruction is a loop instruction |
| pc | input | AW | Address of the executing instruction |
| loop_end_in | input | AW | Last body address field of the loop instruction |
| loop_count_in | input | CW | Iteration count field of the loop instruction |
| end_hit | output | 1 | `pc` is at the innermost active loop's last address |
| redirect | output | 1 | Next fetch comes from `redirect_addr` |
| redirect_addr | output | AW | First body address of the loop being repeated |
| loop_exit | output | 1 | A loop finished here and fetch falls through |
| ovf_err | output | 1 | Sticky: a loop instruction arrived with the stack full |

## Verification
The bench builds the block with 8-bit addresses, 8-bit counts and the default depth of four. Small, readable programs in a 64-word address space can then reach every feature: a full four-deep stack with a fifth push to trigger overflow, the four-level shared-end nest with tens of thousands of executed instructions, and stall cycles placed on a loop's last address. The bench acts as a small sequencer that follows `redirect`. It counts how often each address executes and compares those counts with products of the loop counts, so nesting, unwinding and iteration arithmetic are all judged from the program's visible flow.

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;
  // Outcome of evaluating the current pc against the active loops
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_REPEAT = 2'd1,
    ACT_EXIT   = 2'd2
  } act_e;
endpackage

// File: rtl/loop_lifo.sv
module loop_lifo #(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push,
  input  logic [AW-1:0]             push_start,
  input  logic [AW-1:0]             push_end,
  input  logic [CW-1:0]             push_left,
  input  logic [PW-1:0]             pop_n,
  input  logic                      dec,
  input  logic [IW-1:0]             dec_idx,
  output logic [PW-1:0]             sp,
  output logic [DEPTH-1:0][AW-1:0]  starts,
  output logic [DEPTH-1:0][AW-1:0]  ends,
  output logic [DEPTH-1:0][CW-1:0]  lefts,
  output logic                      ovf
);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  // named internal events
  logic push_ok, push_full;
  assign push_ok   = push && (sp != FULL);
  assign push_full = push && (sp == FULL);

  // three lock-step stacks, one write port per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (push_ok && (sp == PW'(g))) begin
        starts[g] <= push_start;
        ends[g]   <= push_end;
        lefts[g]  <= push_left;
      end else if (dec && (dec_idx == IW'(g))) begin
        lefts[g]  <= lefts[g] - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp  <= '0;
      ovf <= 1'b0;
    end else begin
      if (push_full) ovf <= 1'b1;
      if (push_ok)   sp  <= sp + PW'(1);
      else           sp  <= sp - pop_n;
    end
  end

  p_sp_bounded_r8: assert property (@(posedge clk) disable iff (rst)
    sp <= FULL);
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  p_full_push_holds_r8: assert property (@(posedge clk) disable iff (rst)
    push_full |=> (sp == FULL) && ovf);
  p_push_grows_r2: assert property (@(posedge clk) disable iff (rst)
    push_ok |=> sp == $past(sp) + PW'(1));
  p_dec_one_r2: assert property (@(posedge clk) disable iff (rst)
    (dec && !push) |=> lefts[$past(dec_idx)] == $past(lefts[dec_idx]) - CW'(1));
endmodule

// File: rtl/loop_resolve.sv
module loop_resolve
  import loop_seq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      eval,
  input  logic [AW-1:0]             pc,
  input  logic [PW-1:0]             sp,
  input  logic [DEPTH-1:0][AW-1:0]  ends,
  input  logic [DEPTH-1:0][CW-1:0]  lefts,
  output logic                      end_hit,
  output act_e                      act,
  output logic [IW-1:0]             hit_idx,
  output logic [PW-1:0]             pop_n
);
  logic          going;
  logic          hit_any;
  logic [IW-1:0] idx;

  // Walk from the innermost loop outward while pc keeps matching:
  // exhausted loops are popped, the first one with iterations left repeats.
  always_comb begin
    going   = eval;
    hit_any = 1'b0;
    end_hit = 1'b0;
    hit_idx = '0;
    pop_n   = '0;
    idx     = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (going && (PW'(k) < sp)) begin
        idx = IW'(sp - PW'(1) - PW'(k));
        if (ends[idx] == pc) begin
          if (k == 0) end_hit = 1'b1;
          if (lefts[idx] != '0) begin
            hit_any = 1'b1;
            hit_idx = idx;
            going   = 1'b0;
          end else begin
            pop_n = pop_n + PW'(1);
          end
        end else begin
          going = 1'b0;
        end
      end else begin
        going = 1'b0;
      end
    end
    if (hit_any)            act = ACT_REPEAT;
    else if (pop_n != '0)   act = ACT_EXIT;
    else                    act = ACT_NONE;
  end

  p_idle_no_action_r10: assert property (@(posedge clk) disable iff (rst)
    !eval |-> (act == ACT_NONE) && (pop_n == '0) && !end_hit);
  p_pops_within_stack_r7: assert property (@(posedge clk) disable iff (rst)
    pop_n <= sp);
endmodule

// File: rtl/loop_seq.sv
module loop_seq
  import loop_seq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          loop_cmd,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] loop_end_in,
  input  logic [CW-1:0] loop_count_in,
  output logic          end_hit,
  output logic          redirect,
  output logic [AW-1:0] redirect_addr,
  output logic          loop_exit,
  output logic          ovf_err
);
  // first body address follows the loop instruction
  function automatic logic [AW-1:0] body_start(input logic [AW-1:0] at);
    return at + AW'(1);
  endfunction

  // repeats still owed after the first pass; 0 and 1 both mean one pass
  function automatic logic [CW-1:0] repeats_owed(input logic [CW-1:0] n);
    return (n == '0) ? '0 : n - CW'(1);
  endfunction

  logic                     push_req, eval;
  logic [PW-1:0]            sp, pop_n;
  logic [DEPTH-1:0][AW-1:0] starts, ends;
  logic [DEPTH-1:0][CW-1:0] lefts;
  logic [IW-1:0]            hit_idx;
  act_e                     act;

  assign push_req = step && loop_cmd;
  assign eval     = step && !loop_cmd;

  loop_lifo #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_lifo (
    .clk        (clk),
    .rst        (rst),
    .push       (push_req),
    .push_start (body_start(pc)),
    .push_end   (loop_end_in),
    .push_left  (repeats_owed(loop_count_in)),
    .pop_n      (pop_n),
    .dec        (redirect),
    .dec_idx    (hit_idx),
    .sp         (sp),
    .starts     (starts),
    .ends       (ends),
    .lefts      (lefts),
    .ovf        (ovf_err)
  );

  loop_resolve #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_resolve (
    .clk     (clk),
    .rst     (rst),
    .eval    (eval),
    .pc      (pc),
    .sp      (sp),
    .ends    (ends),
    .lefts   (lefts),
    .end_hit (end_hit),
    .act     (act),
    .hit_idx (hit_idx),
    .pop_n   (pop_n)
  );

  assign redirect      = (act == ACT_REPEAT);
  assign loop_exit     = (act == ACT_EXIT);
  assign redirect_addr = redirect ? starts[hit_idx] : '0;

  p_redirect_needs_end_r5: assert property (@(posedge clk) disable iff (rst)
    redirect |-> end_hit);
  p_empty_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (sp == '0) |-> !end_hit && !redirect && !loop_exit);
  p_stall_no_consume_r10: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(sp));
endmodule

// File: tb/tb_loop_seq.sv
module tb_loop_seq;
  localparam int AW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          step = 1'b0;
  logic          loop_cmd = 1'b0;
  logic [AW-1:0] pc = '0;
  logic [AW-1:0] loop_end_in = '0;
  logic [CW-1:0] loop_count_in = '0;
  logic          end_hit, redirect, loop_exit, ovf_err;
  logic [AW-1:0] redirect_addr;

  always #5 clk = ~clk;

  loop_seq #(.AW(AW), .CW(CW), .DEPTH(4)) dut (
    .clk(clk), .rst(rst), .step(step), .loop_cmd(loop_cmd), .pc(pc),
    .loop_end_in(loop_end_in), .loop_count_in(loop_count_in),
    .end_hit(end_hit), .redirect(redirect), .redirect_addr(redirect_addr),
    .loop_exit(loop_exit), .ovf_err(ovf_err)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // program image: loop instructions by address
  bit prog_loop [64];
  int prog_end  [64];
  int prog_cnt  [64];
  int visits    [64];
  int first_target, hits, exits;

  typedef struct { int addr; int n; string req; } exp_t;
  exp_t sb_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int a = 0; a < 64; a++) begin
      prog_loop[a] = 1'b0; prog_end[a] = 0; prog_cnt[a] = 0;
    end
  endtask

  task automatic add_loop(input int at, input int n, input int last);
    prog_loop[at] = 1'b1; prog_cnt[at] = n; prog_end[at] = last;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; step = 1'b0; loop_cmd = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // driver side: expected visit counts go into the scoreboard queue
  task automatic expect_visits(input int addr, input int n, input string req);
    exp_t e;
    e.addr = addr; e.n = n; e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor side: pop each expectation and compare with what was seen
  task automatic drain();
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(visits[e.addr] == e.n, e.req, visits[e.addr], e.n);
    end
  endtask

  // sequencer model: follows redirect, otherwise pc+1
  task automatic run_prog(input int start, input int stop, input int stall);
    int cur, nxt, steps;
    cur = start; steps = 0; first_target = -1; hits = 0; exits = 0;
    for (int a = 0; a < 64; a++) visits[a] = 0;
    while (cur != stop && cur >= 0 && cur < 64 && steps < 60000) begin
      @(negedge clk);
      pc = AW'(cur);
      loop_cmd = prog_loop[cur];
      loop_end_in = AW'(prog_end[cur]);
      loop_count_in = CW'(prog_cnt[cur]);
      if (cur == stall) begin
        step = 1'b0;
        #2;
        check(!redirect && !end_hit, "R10 stall cycle quiet",
              int'(redirect) + int'(end_hit), 0);
        @(negedge clk);
      end
      step = 1'b1;
      #2;
      visits[cur]++;
      if (end_hit) hits++;
      if (loop_exit) exits++;
      if (redirect) begin
        if (first_target < 0) first_target = int'(redirect_addr);
        nxt = int'(redirect_addr);
      end else begin
        nxt = cur + 1;
      end
      cur = nxt;
      steps++;
    end
    @(negedge clk);
    step = 1'b0; loop_cmd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    // ---- R1: reset state
    clear_prog();
    do_reset();
    @(negedge clk);
    step = 1'b1; pc = 8'd13;
    #2;
    check(!end_hit && !redirect && !loop_exit, "R1 quiet after reset",
          int'(end_hit) + int'(redirect) + int'(loop_exit), 0);
    check(!ovf_err, "R1 ovf_err clear", int'(ovf_err), 0);
    @(negedge clk); step = 1'b0;

    // ---- R2/R3/R5: single loop at 10, four passes over 11..13
    clear_prog(); add_loop(10, 4, 13);
    do_reset();
    run_prog(10, 15, -1);
    expect_visits(11, 4, "R2 body start visits");
    expect_visits(13, 4, "R2 body end visits");
    expect_visits(14, 1, "R2 fall through once");
    drain();
    check(first_target == 11, "R3 redirect target", first_target, 11);
    check(hits == 4, "R5 end_hit count", hits, 4);
    check(exits == 1, "R2 loop_exit count", exits, 1);

    // ---- R9: stack empty now, revisit old last address
    @(negedge clk);
    step = 1'b1; loop_cmd = 1'b0; pc = 8'd13;
    #2;
    check(!end_hit && !redirect && !loop_exit, "R9 empty stack ignored",
          int'(end_hit) + int'(redirect) + int'(loop_exit), 0);
    @(negedge clk); step = 1'b0;

    // ---- R4: counts of zero and one
    clear_prog(); add_loop(20, 0, 22);
    do_reset();
    run_prog(20, 24, -1);
    expect_visits(21, 1, "R4 count zero body once");
    expect_visits(22, 1, "R4 count zero end once");
    drain();
    check(first_target < 0, "R4 count zero no redirect", first_target, -1);
    clear_prog(); add_loop(20, 1, 22);
    do_reset();
    run_prog(20, 24, -1);
    expect_visits(22, 1, "R4 count one end once");
    expect_visits(23, 1, "R4 count one fall through");
    drain();
    check(first_target < 0, "R4 count one no redirect", first_target, -1);

    // ---- R6/R7: four-deep nest, two loops sharing last address 35
    clear_prog();
    add_loop(24, 5, 35); add_loop(26, 10, 35);
    add_loop(29, 20, 34); add_loop(31, 12, 33);
    do_reset();
    run_prog(23, 36, -1);
    expect_visits(25, 5,     "R7 outer body visits");
    expect_visits(27, 50,    "R7 shared-end inner body");
    expect_visits(35, 50,    "R7 shared last address");
    expect_visits(30, 1000,  "R6 outer resumes after inner");
    expect_visits(32, 12000, "R6 innermost body");
    expect_visits(34, 1000,  "R6 enclosing end visits");
    drain();
    check(exits == 1 + 50 + 1000, "R7 exit events", exits, 1051);

    // ---- R8: fifth push while full
    clear_prog();
    add_loop(40, 2, 50); add_loop(41, 2, 49); add_loop(42, 2, 48);
    add_loop(43, 2, 47); add_loop(44, 3, 46);
    do_reset();
    run_prog(40, 52, -1);
    expect_visits(44, 16, "R8 full-stack pushes attempted");
    expect_visits(46, 16, "R8 dropped loop has no effect");
    expect_visits(47, 16, "R8 fourth loop intact");
    expect_visits(50, 2,  "R8 outer loop intact");
    drain();
    check(ovf_err, "R8 ovf_err set", int'(ovf_err), 1);
    repeat (3) @(negedge clk);
    #2;
    check(ovf_err, "R8 ovf_err sticky", int'(ovf_err), 1);
    do_reset();
    #2;
    check(!ovf_err, "R1 reset clears ovf_err", int'(ovf_err), 0);

    // ---- R10: stall on the last address each pass
    clear_prog(); add_loop(10, 3, 13);
    do_reset();
    run_prog(10, 15, 13);
    expect_visits(13, 3, "R10 stalls consume nothing");
    expect_visits(14, 1, "R10 fall through once");
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule